// File: doc/BRIEF.md
# Non-Power-of-Two Modulus Sawtooth PWM Generator

This block is a tone source for audio-style outputs. A phase accumulator whose modulus is a decimal value (LEVELS × 2^FRAC, 16000 by default) counts down by a loadable tuning word. Its integer part drives a pulse-width modulator directly, so the filtered output is a sawtooth. Because the modulus is not a power of two, the tuning word can be an exact binary fraction of a round frequency. The output phase also always stays inside the modulator's 0 to LEVELS-1 range.

The accumulator moves once per PWM period. In the default setting this is 1000 clocks, which gives 32,000 updates per second from a 32 MHz clock. On a step that goes below zero, the accumulator adds the modulus back. The wrap uses one subtractor. Its second operand is chosen between the step and a precomputed "step minus modulus". That choice comes from a borrow flag sampled during the idle clocks of the period.

A new tuning word is first written to a staging copy. It becomes active at the next period boundary. The block also gives other logic two strobes from the same clock: a one-clock sample strobe once per PWM period, and a one-clock strobe every millisecond.

Top module: `sawpwm_gen`

## Requirements
- R1: After a synchronous reset, pwm_o, sample_stb_o and ms_stb_o are low, the accumulator is 0 and the active and staged step are 0, so the first PWM period has duty 0.
- R2: At each PWM period boundary the accumulator A becomes A - S when A >= S, where S is the active step. It holds its value on every other clock.
- R3: When A < S, the new value is A - S + MOD with MOD = LEVELS × 2^FRAC. The accumulator stays within 0..MOD-1, and the duty (A >> FRAC) never exceeds LEVELS-1.
- R4: An active step of 0 freezes the accumulator and therefore the duty.
- R5: A step presented with step_load_i high is staged. It becomes active at the first period boundary after the load edge.
- R6: A load that arrives on the last clock of a PWM period (the boundary clock) is dropped. The staged step keeps its old value.
- R7: In each PWM period, pwm_o is high for exactly D clocks, where D is the duty latched at the start of that period from the accumulator value before its update. The output is low on the clock after the boundary.
- R8: sample_stb_o pulses for one clock every LEVELS clocks. The first pulse comes LEVELS clocks after reset is released, in the same clock as the accumulator update becomes visible.
- R9: ms_stb_o pulses for one clock every MS_CLKS clocks. The first pulse comes MS_CLKS clocks after reset is released.
- R10: A reset asserted in mid-run returns every output and every state to the R1 condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | ACC_W (14) | Tuning word, must be below MOD |
| step_load_i | input | 1 | Stage step_i on this clock |
| pwm_o | output | 1 | Registered PWM output |
| sample_stb_o | output | 1 | One-clock strobe per PWM period |
| ms_stb_o | output | 1 | One-clock strobe every MS_CLKS clocks |

## Verification
A wrong accumulator value, a missed wrap correction or a mismatched operand select shows up at pwm_o within one PWM period. The high-clock count of the next period then differs from the duty expected by the model. A stale or early step shows up one period later as a wrong descent rate of the sawtooth. Counter faults move sample_stb_o or ms_stb_o off their expected clocks at the first strobe that follows.

// File: rtl/sawpwm_pkg.sv
package sawpwm_pkg;

  // Which second operand the shared subtractor uses.
  typedef enum logic {
    OPD_STEP    = 1'b0,  // acc - step
    OPD_WRAPPED = 1'b1   // acc - (step - MOD) = acc - step + MOD
  } opd_sel_e;

endpackage

// File: rtl/sawpwm_period_gen.sv
module sawpwm_period_gen #(
  parameter int LEVELS = 1000,
  localparam int CNT_W = $clog2(LEVELS)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             sample_stb_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(LEVELS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q        <= '0;
      sample_stb_o <= 1'b0;
    end else begin
      cnt_q        <= wrap_o ? '0 : cnt_q + 1'b1;
      sample_stb_o <= wrap_o;
    end
  end

  // R8
  stb_after_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (sample_stb_o && cnt_q == '0));

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

endmodule

// File: rtl/sawpwm_phase_acc.sv
module sawpwm_phase_acc
  import sawpwm_pkg::*;
#(
  parameter int MOD = 16000,
  localparam int ACC_W = $clog2(MOD),
  localparam int DIF_W = ACC_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap_i,
  input  logic [ACC_W-1:0] step_i,
  input  logic             load_i,
  output logic [ACC_W-1:0] acc_o
);

  localparam logic [DIF_W-1:0] MOD_V = DIF_W'(MOD);

  logic [ACC_W-1:0] stage_step, act_step, acc_q;
  logic [DIF_W-1:0] stage_pre, act_pre, opd, diff;
  opd_sel_e         sel_q;
  logic             borrow;

  // Step minus modulus, formed once at load time, away from the update path.
  logic [DIF_W-1:0] pre_in;
  assign pre_in = {1'b0, step_i} - MOD_V;

  // One subtractor, operand muxed.
  assign opd    = (sel_q == OPD_WRAPPED) ? act_pre : {1'b0, act_step};
  assign diff   = {1'b0, acc_q} - opd;
  assign borrow = diff[DIF_W-1];
  assign acc_o  = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_step <= '0;
      stage_pre  <= '0 - MOD_V;
      act_step   <= '0;
      act_pre    <= '0 - MOD_V;
      acc_q      <= '0;
      sel_q      <= OPD_STEP;
    end else begin
      if (load_i && !wrap_i) begin
        stage_step <= step_i;
        stage_pre  <= pre_in;
      end
      if (wrap_i) begin
        acc_q    <= diff[ACC_W-1:0];
        act_step <= stage_step;
        act_pre  <= stage_pre;
        sel_q    <= OPD_STEP;
      end else if (sel_q == OPD_STEP && borrow) begin
        sel_q <= OPD_WRAPPED;
      end
    end
  end

  // R3
  acc_range_chk: assert property (@(posedge clk) disable iff (rst)
    acc_q < ACC_W'(MOD));

  // R2
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap_i |=> $stable(acc_q));

  // R3
  wrap_sel_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_i |-> ((sel_q == OPD_WRAPPED) == (acc_q < act_step)));

  // R6
  drop_load_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_i |=> $stable(stage_step));

  // R4
  zero_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap_i && act_step == '0) |=> $stable(acc_q));

endmodule

// File: rtl/sawpwm_duty_out.sv
module sawpwm_duty_out #(
  parameter int LEVELS = 1000,
  parameter int FRAC   = 4,
  localparam int CNT_W = $clog2(LEVELS),
  localparam int ACC_W = CNT_W + FRAC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic             pwm_o
);

  logic [CNT_W-1:0] duty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q <= '0;
      pwm_o  <= 1'b0;
    end else begin
      if (wrap_i) duty_q <= acc_i[ACC_W-1:FRAC];
      pwm_o <= (cnt_i < duty_q);
    end
  end

  // R3
  duty_max_chk: assert property (@(posedge clk) disable iff (rst)
    duty_q <= CNT_W'(LEVELS - 1));

  // R7
  duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap_i |=> $stable(duty_q));

  // R7
  pwm_low_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_i |=> !pwm_o);

endmodule

// File: rtl/sawpwm_ms_tick.sv
module sawpwm_ms_tick #(
  parameter int MS_CLKS = 32000,
  localparam int PW = $clog2(MS_CLKS)
) (
  input  logic clk,
  input  logic rst,
  output logic stb_o
);

  localparam logic [PW-1:0] LAST = PW'(MS_CLKS - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      stb_o <= 1'b0;
    end else begin
      pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
      stb_o <= (pre_q == LAST);
    end
  end

  // R9
  pre_range_chk: assert property (@(posedge clk) disable iff (rst)
    pre_q <= LAST);

  generate
    if (MS_CLKS > 1) begin : g_width
      // R9
      ms_single_chk: assert property (@(posedge clk) disable iff (rst)
        stb_o |=> !stb_o);
    end
  endgenerate

endmodule

// File: rtl/sawpwm_gen.sv
module sawpwm_gen #(
  parameter int LEVELS  = 1000,
  parameter int FRAC    = 4,
  parameter int MS_CLKS = 32000,
  localparam int MOD    = LEVELS * (2 ** FRAC),
  localparam int CNT_W  = $clog2(LEVELS),
  localparam int ACC_W  = CNT_W + FRAC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] step_i,
  input  logic             step_load_i,
  output logic             pwm_o,
  output logic             sample_stb_o,
  output logic             ms_stb_o
);

  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [ACC_W-1:0] acc;

  sawpwm_period_gen #(.LEVELS(LEVELS)) u_period (
    .clk(clk), .rst(rst), .cnt_o(cnt), .wrap_o(wrap),
    .sample_stb_o(sample_stb_o)
  );

  sawpwm_phase_acc #(.MOD(MOD)) u_acc (
    .clk(clk), .rst(rst), .wrap_i(wrap), .step_i(step_i),
    .load_i(step_load_i), .acc_o(acc)
  );

  sawpwm_duty_out #(.LEVELS(LEVELS), .FRAC(FRAC)) u_duty (
    .clk(clk), .rst(rst), .wrap_i(wrap), .cnt_i(cnt), .acc_i(acc),
    .pwm_o(pwm_o)
  );

  sawpwm_ms_tick #(.MS_CLKS(MS_CLKS)) u_ms (
    .clk(clk), .rst(rst), .stb_o(ms_stb_o)
  );

endmodule

// File: tb/sawpwm_gen_bench.sv
module sawpwm_gen_bench;

  localparam int LEVELS  = 1000;
  localparam int FRAC    = 4;
  localparam int MS_CLKS = 32000;
  localparam int MOD     = LEVELS * (2 ** FRAC);
  localparam int ACC_W   = $clog2(LEVELS) + FRAC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ACC_W-1:0] step_i = '0;
  logic step_load_i = 1'b0;
  logic pwm_o, sample_stb_o, ms_stb_o;

  always #4 clk = ~clk;  // 125 MHz

  sawpwm_gen #(.LEVELS(LEVELS), .FRAC(FRAC), .MS_CLKS(MS_CLKS)) u_sawpwm_gen (
    .clk(clk), .rst(rst), .step_i(step_i), .step_load_i(step_load_i),
    .pwm_o(pwm_o), .sample_stb_o(sample_stb_o), .ms_stb_o(ms_stb_o)
  );

  int n_cmp = 0, n_bad = 0;
  int edges = 0;
  bit done = 0;
  string tag = "R1";

  // model state
  int m_acc = 0, m_act = 0, m_stage = 0, exp_duty = 0, hi_cnt = 0;
  int last_stb = 0, last_ms = 0;
  bit have_win = 0;

  task automatic check(bit ok, string req, int act, int exp, string what);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int acc_next(int a, int s);
    return (a >= s) ? a - s : a - s + MOD;
  endfunction

  always @(posedge clk) edges <= rst ? 0 : edges + 1;

  always @(negedge clk) begin
    if (rst) begin
      m_acc = 0; m_act = 0; m_stage = 0; exp_duty = 0; hi_cnt = 0;
      last_stb = 0; last_ms = 0; have_win = 0;
    end else begin
      if (have_win) hi_cnt += int'(pwm_o);
      if (sample_stb_o) begin
        check(edges - last_stb == LEVELS, "R8", edges - last_stb, LEVELS, "sample strobe spacing");
        if (have_win) begin
          check(hi_cnt == exp_duty, tag, hi_cnt, exp_duty, "high clocks per period");
          check(hi_cnt <= LEVELS - 1, "R3", hi_cnt, LEVELS - 1, "duty bound");
        end
        exp_duty = m_acc >> FRAC;
        m_acc    = acc_next(m_acc, m_act);
        m_act    = m_stage;
        hi_cnt   = 0;
        have_win = 1;
        last_stb = edges;
      end
      if (ms_stb_o) begin
        check(edges - last_ms == MS_CLKS, "R9", edges - last_ms, MS_CLKS, "ms strobe spacing");
        last_ms = edges;
      end
    end
  end

  task automatic load(int v, bit on_boundary);
    @(negedge clk); #1;
    if (on_boundary) begin
      while (edges % LEVELS != LEVELS - 1) begin @(negedge clk); #1; end
    end else if (edges % LEVELS == LEVELS - 1) begin
      @(negedge clk); #1;
    end
    step_i = ACC_W'(v);
    step_load_i = 1'b1;
    if (edges % LEVELS != LEVELS - 1) m_stage = v;  // R6: boundary load dropped
    @(negedge clk); #1;
    step_load_i = 1'b0;
  endtask

  task automatic run_periods(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      while (!sample_stb_o) @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    @(negedge clk); #1 rst = 1'b0;
    // R1: outputs low just after reset release
    @(negedge clk);
    check(pwm_o == 0, "R1", int'(pwm_o), 0, "pwm after reset");
    check(sample_stb_o == 0, "R1", int'(sample_stb_o), 0, "sample strobe after reset");
    check(ms_stb_o == 0, "R1", int'(ms_stb_o), 0, "ms strobe after reset");
    tag = "R1";
    run_periods(3);
    // R2: plain descent
    tag = "R2";
    load(800, 0);
    run_periods(22);
    // R4: zero step freezes at a nonzero level
    tag = "R4";
    load(0, 0);
    run_periods(5);
    // R3 / R5: random steps
    for (int j = 0; j < 5; j++) begin
      tag = (j % 2 == 0) ? "R3" : "R5";
      load(1 + int'($urandom % (MOD - 1)), 0);
      run_periods(9);
    end
    // R3: extreme steps
    tag = "R3";
    load(MOD - 1, 0);
    run_periods(6);
    load(1, 0);
    run_periods(3);
    // R6: boundary load is dropped
    tag = "R6";
    load(5000, 1);
    run_periods(4);
    // R7: mid-range step, output width checks
    tag = "R7";
    load(3333, 0);
    run_periods(6);
    // R10: mid-run reset
    @(negedge clk); #1 rst = 1'b1;
    repeat (3) @(negedge clk);
    check(pwm_o == 0, "R10", int'(pwm_o), 0, "pwm in reset");
    check(sample_stb_o == 0 && ms_stb_o == 0, "R10", int'(sample_stb_o | ms_stb_o), 0, "strobes in reset");
    #1 rst = 1'b0;
    tag = "R10";
    run_periods(3);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule